// File: doc/BRIEF.md
# Horner Polynomial Evaluator

This block computes the value of a polynomial at a signed fixed-point argument by nesting multiply and add steps (Horner's scheme). A caller presents the argument, the polynomial degree and the address of the coefficient table together with a one-cycle start strobe. The block then walks the table through a synchronous-read memory port. It returns the result, sign and zero flags, and a fault indication, all signalled by a one-cycle done pulse.

All values are signed Q16.16: 32 bits, of which 16 are fraction bits. The table holds the leading (highest-power) coefficient at the base address, and each lower power sits one word higher, ending with the constant term at base+degree. The running value starts at the leading coefficient. Each later coefficient c produces acc <- round(acc*x) + c, so the result is C[0] + x*(C[1] + x*(... + x*C[d])). A per-start trap-enable input selects the underflow behaviour. When it is set, an underflow ends the run with a fault. When it is clear, the running value is forced to zero and the walk carries on.

Top module: `horner_eval`

## Requirements
- R1: After reset, done, mem_rd_en, all three fault outputs, result, flag_n and flag_z are all 0.
- R2: For degree d, the block reads addresses base, base+1, ... base+d in that order, one read per coefficient. The word at base is the coefficient of x^d. The result equals the nested evaluation, with the memory port idle whenever the block is idle.
- R3: A degree of 0 reads exactly one word and returns it unchanged as the result.
- R4: A degree above 31 pulses done with fault_rsv=1 on the first clock edge after start. It makes no memory read and leaves result and flags unchanged.
- R5: Each product is rounded to the nearest Q16.16 value, with an exact half rounding toward +infinity. For example, -0.5 * 2^-16 rounds to 0.
- R6: If a rounded product or a sum leaves the signed 32-bit range, the run stops at that step with fault_ovf=1 and done. No further reads are made, and result and flags are unchanged.
- R7: An underflow is a step whose rounded sum is zero while the exact product plus coefficient is nonzero. With the trap enable set, an underflow ends the run with fault_unf=1 and done, no further reads, and result unchanged.
- R8: With the trap enable clear, an underflowing step sets the running value to zero without a fault, and the walk continues, so a later coefficient can still make the result nonzero.
- R9: After a fault-free run, flag_n equals bit 31 of the result and flag_z is 1 exactly when the result is zero.
- R10: done is high for exactly one cycle per run. Result and flags change only in that cycle and hold until a later run completes. A start while a run is busy is ignored. At most one fault output is high, and fault outputs clear on the next accepted start.
- R11: A run of degree d (at most 31) takes 2 cycles per coefficient. done is visible after the (2d+3)th rising edge, counting the edge that samples start as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request, taken only while idle |
| arg_x | input | 32 | Argument, signed Q16.16 |
| degree | input | 16 | Unsigned polynomial degree |
| base_addr | input | 8 | Address of the leading coefficient |
| unf_trap | input | 1 | 1: underflow faults; 0: underflow zeroes and continues |
| mem_rd_en | output | 1 | Coefficient read strobe |
| mem_addr | output | 8 | Coefficient read address |
| mem_rdata | input | 32 | Read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Signed Q16.16 result |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| fault_rsv | output | 1 | Degree out of range |
| fault_ovf | output | 1 | Arithmetic overflow |
| fault_unf | output | 1 | Trapped underflow |

## Verification
The hardest condition to reach from the ports is an underflow in a middle step that is later masked by a nonzero constant term. The product must round to zero from a nonzero value while the coefficient added is zero. The stimulus uses the smallest positive argument (raw value 1) with a leading coefficient of 0.25. The product then becomes 0.25 units of the last place and rounds to zero. The same table is then rerun with the trap enabled, to show that the fault stops the walk after the second read and keeps the earlier result. Exact-half rounding of negative products and the overflow found only in the sum (not the product) are reached with hand-chosen tables of the same kind.

// File: rtl/horner_pkg.sv
package horner_pkg;
    localparam int unsigned Q_W     = 32;
    localparam int unsigned Q_FRAC  = 16;
    localparam int unsigned DEG_W   = 16;
    localparam int unsigned MAX_DEG = 31;
    localparam int unsigned CNT_W   = $clog2(MAX_DEG + 1);
    localparam int unsigned ADDR_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [Q_W-1:0] value;
        logic           ovf;
        logic           unf;
    } step_out_t;

    typedef struct packed {
        logic rsv;
        logic ovf;
        logic unf;
    } fault_t;
endpackage

// File: rtl/horner_step.sv
module horner_step
    import horner_pkg::*;
#(
    parameter int unsigned DW = Q_W,
    parameter int unsigned FW = Q_FRAC
) (
    input  logic signed [DW-1:0] acc_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] coef_i,
    output logic [DW-1:0]        value_o,
    output logic                 ovf_o,
    output logic                 unf_o
);
    localparam int unsigned PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd_full;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] exact;
    logic signed [DW:0]   sum;
    logic                 ovf_prod;

    always_comb begin
        prod     = PW'(acc_i) * PW'(x_i);
        rnd_full = prod + (PW'(1) <<< (FW - 1));
        rnd      = rnd_full >>> FW;
        ovf_prod = (rnd[PW-1:DW-1] != {(PW-DW+1){rnd[DW-1]}});
        sum      = (DW+1)'($signed(rnd[DW-1:0])) + (DW+1)'(coef_i);
        exact    = prod + (PW'(coef_i) <<< FW);
        ovf_o    = ovf_prod | (sum[DW] != sum[DW-1]);
        unf_o    = !ovf_o && (sum[DW-1:0] == '0) && (exact != '0);
        value_o  = sum[DW-1:0];
    end
endmodule

// File: rtl/horner_seq.sv
module horner_seq
    import horner_pkg::*;
#(
    parameter int unsigned DW   = Q_W,
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned DGW  = DEG_W,
    parameter int unsigned MAXD = MAX_DEG
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [DW-1:0]  arg_x,
    input  logic [DGW-1:0] degree,
    input  logic [AW-1:0]  base_addr,
    input  logic           unf_trap,
    output logic           mem_rd_en,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic [DW-1:0]  acc_o,
    output logic [DW-1:0]  x_o,
    input  step_out_t      step_i,
    output logic           busy,
    output logic           done,
    output logic [DW-1:0]  result,
    output logic           flag_n,
    output logic           flag_z,
    output fault_t         fault
);
    localparam int unsigned LW = $clog2(MAXD + 1);

    seq_state_e     state_q;
    logic [DW-1:0]  x_q, acc_q, res_q;
    logic [AW-1:0]  addr_q;
    logic [LW-1:0]  left_q;
    logic           first_q, trap_q, done_q, n_q, z_q;
    fault_t         fault_q;

    logic [DW-1:0]  load_val;
    logic           step_bad;

    always_comb begin
        load_val = first_q ? mem_rdata : (step_i.unf ? '0 : step_i.value);
        step_bad = !first_q && (step_i.ovf || (step_i.unf && trap_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            x_q     <= '0;
            acc_q   <= '0;
            res_q   <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            first_q <= 1'b0;
            trap_q  <= 1'b0;
            done_q  <= 1'b0;
            n_q     <= 1'b0;
            z_q     <= 1'b0;
            fault_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        fault_q <= '0;
                        if (degree > DGW'(MAXD)) begin
                            fault_q.rsv <= 1'b1;
                            done_q      <= 1'b1;
                        end else begin
                            x_q     <= arg_x;
                            addr_q  <= base_addr;
                            left_q  <= degree[LW-1:0];
                            first_q <= 1'b1;
                            trap_q  <= unf_trap;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state_q <= ST_LOAD;
                ST_LOAD: begin
                    first_q <= 1'b0;
                    if (step_bad) begin
                        fault_q.ovf <= step_i.ovf;
                        fault_q.unf <= !step_i.ovf;
                        done_q      <= 1'b1;
                        state_q     <= ST_IDLE;
                    end else begin
                        acc_q <= load_val;
                        if (left_q == '0) begin
                            res_q   <= load_val;
                            n_q     <= load_val[DW-1];
                            z_q     <= (load_val == '0);
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            left_q  <= left_q - LW'(1);
                            addr_q  <= addr_q + AW'(1);
                            state_q <= ST_FETCH;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en = (state_q == ST_FETCH);
    assign mem_addr  = addr_q;
    assign acc_o     = acc_q;
    assign x_o       = x_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign result    = res_q;
    assign flag_n    = n_q;
    assign flag_z    = z_q;
    assign fault     = fault_q;
endmodule

// File: rtl/horner_eval.sv
module horner_eval
    import horner_pkg::*;
#(
    parameter int unsigned DW  = Q_W,
    parameter int unsigned FW  = Q_FRAC,
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned DGW = DEG_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [DW-1:0]  arg_x,
    input  logic [DGW-1:0] degree,
    input  logic [AW-1:0]  base_addr,
    input  logic           unf_trap,
    output logic           mem_rd_en,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           done,
    output logic [DW-1:0]  result,
    output logic           flag_n,
    output logic           flag_z,
    output logic           fault_rsv,
    output logic           fault_ovf,
    output logic           fault_unf
);
    logic [DW-1:0] acc_w, x_w, step_val;
    logic          step_ovf, step_unf, busy;
    step_out_t     step_w;
    fault_t        fault_w;

    horner_step #(.DW(DW), .FW(FW)) step_i (
        .acc_i   ($signed(acc_w)),
        .x_i     ($signed(x_w)),
        .coef_i  ($signed(mem_rdata)),
        .value_o (step_val),
        .ovf_o   (step_ovf),
        .unf_o   (step_unf)
    );

    assign step_w = '{value: step_val, ovf: step_ovf, unf: step_unf};

    horner_seq #(.DW(DW), .AW(AW), .DGW(DGW), .MAXD(MAX_DEG)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .arg_x     (arg_x),
        .degree    (degree),
        .base_addr (base_addr),
        .unf_trap  (unf_trap),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .acc_o     (acc_w),
        .x_o       (x_w),
        .step_i    (step_w),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .fault     (fault_w)
    );

    assign fault_rsv = fault_w.rsv;
    assign fault_ovf = fault_w.ovf;
    assign fault_unf = fault_w.unf;
endmodule

// File: rtl/horner_eval_chk.sv
module horner_eval_chk #(
    parameter int unsigned DW  = 32,
    parameter int unsigned DGW = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic [DGW-1:0] degree,
    input logic           done,
    input logic           mem_rd_en,
    input logic [DW-1:0]  result,
    input logic           flag_n,
    input logic           flag_z,
    input logic           fault_rsv,
    input logic           fault_ovf,
    input logic           fault_unf
);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    p_fault_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_rsv, fault_ovf, fault_unf}));

    p_ovf_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_ovf) |-> done);

    p_unf_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_unf) |-> done);

    p_rsv_fast_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (degree > DGW'(31))) |=> (done && fault_rsv && !mem_rd_en));

    p_idle_noread_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_en);

    p_flag_z_r9: assert property (@(posedge clk) disable iff (rst)
        flag_z |-> (result == '0));

    p_flag_n_r9: assert property (@(posedge clk) disable iff (rst)
        flag_n |-> result[DW-1]);
endmodule

bind horner_eval horner_eval_chk #(.DW(DW), .DGW(DGW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .degree    (degree),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .fault_rsv (fault_rsv),
    .fault_ovf (fault_ovf),
    .fault_unf (fault_unf)
);

// File: tb/horner_eval_tb_top.sv
module horner_eval_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] arg_x = '0;
    logic [15:0] degree = '0;
    logic [7:0]  base_addr = '0;
    logic        unf_trap = 1'b0;
    logic        mem_rd_en;
    logic [7:0]  mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        done, flag_n, flag_z, fault_rsv, fault_ovf, fault_unf;
    logic [31:0] result;

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    logic [7:0]  rd_log [0:63];
    logic [31:0] mem [0:255];

    always #10 clk = ~clk;

    horner_eval dut_i (
        .clk(clk), .rst(rst), .start(start), .arg_x(arg_x), .degree(degree),
        .base_addr(base_addr), .unf_trap(unf_trap), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .fault_rsv(fault_rsv),
        .fault_ovf(fault_ovf), .fault_unf(fault_unf)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_log[rd_cnt % 64] = mem_addr;
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    int          n_edges;
    int          rd_base;
    logic [31:0] r_res;
    logic [3:0]  r_flags;

    task automatic run(input logic [31:0] x, input logic [15:0] d,
                       input logic [7:0] b, input logic trap);
        @(negedge clk);
        arg_x = x; degree = d; base_addr = b; unf_trap = trap; start = 1'b1;
        rd_base = rd_cnt;
        n_edges = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            n_edges++;
            @(negedge clk);
            start = 1'b0;
            if (done) break;
        end
        if (!done) chk("watchdog run", 32'd0, 32'd1);
        r_res   = result;
        r_flags = {flag_n, flag_z, fault_ovf, fault_unf};
        @(negedge clk);
        chk("R10 done pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic chk_reads(input string req, input int cnt, input logic [7:0] b);
        chk(req, rd_cnt - rd_base, cnt);
        for (int i = 0; i < cnt; i++)
            chk(req, {24'd0, rd_log[(rd_base + i) % 64]}, {24'd0, b + 8'(i)});
    endtask

    task automatic t_reset();
        chk("R1 done", {31'd0, done}, 0);
        chk("R1 rd_en", {31'd0, mem_rd_en}, 0);
        chk("R1 faults", {29'd0, fault_rsv, fault_ovf, fault_unf}, 0);
        chk("R1 result", result, 0);
        chk("R1 flags", {30'd0, flag_n, flag_z}, 0);
    endtask

    task automatic t_basic();
        mem[4] = 32'h0000_4000; mem[5] = 32'h0000_8000; mem[6] = 32'h0001_0000;
        run(32'h0002_0000, 16'd2, 8'd4, 1'b0);
        chk("R2 result", result, 32'h0003_0000);
        chk_reads("R2 order", 3, 8'd4);
        chk("R11 latency d2", n_edges, 7);
        chk("R9 flags pos", {28'd0, r_flags}, 32'h0);
    endtask

    task automatic t_negative();
        mem[10] = 32'h0001_0000; mem[11] = 32'hFFFE_0000;
        run(32'hFFFE_8000, 16'd1, 8'd10, 1'b0);
        chk("R2 neg result", result, 32'hFFFC_8000);
        chk("R9 flag_n", {28'd0, r_flags}, 32'h8);
    endtask

    task automatic t_zero_result();
        mem[14] = 32'h0001_0000; mem[15] = 32'hFFFF_0000;
        run(32'h0001_0000, 16'd1, 8'd14, 1'b1);
        chk("R9 zero result", result, 32'h0);
        chk("R9 flag_z", {28'd0, r_flags}, 32'h4);
    endtask

    task automatic t_deg0();
        mem[20] = 32'h0001_2345;
        run(32'h1234_0000, 16'd0, 8'd20, 1'b0);
        chk("R3 result", result, 32'h0001_2345);
        chk_reads("R3 reads", 1, 8'd20);
        chk("R11 latency d0", n_edges, 3);
    endtask

    task automatic t_round();
        mem[40] = 32'h0000_8000; mem[41] = 32'h0001_0000;
        run(32'h0000_0001, 16'd1, 8'd40, 1'b1);
        chk("R5 half up", result, 32'h0001_0001);
        mem[40] = 32'h0000_7FFF;
        run(32'h0000_0001, 16'd1, 8'd40, 1'b1);
        chk("R5 below half", result, 32'h0001_0000);
        mem[40] = 32'hFFFF_8000;
        run(32'h0000_0001, 16'd1, 8'd40, 1'b1);
        chk("R5 neg half", result, 32'h0001_0000);
        chk("R5 no fault", {28'd0, r_flags}, 32'h0);
    endtask

    task automatic t_underflow();
        mem[50] = 32'h0000_4000; mem[51] = 32'h0; mem[52] = 32'h0002_0000;
        run(32'h0000_0001, 16'd2, 8'd50, 1'b0);
        chk("R8 continue result", result, 32'h0002_0000);
        chk("R8 no fault", {28'd0, r_flags}, 32'h0);
        chk_reads("R8 reads", 3, 8'd50);
        run(32'h0000_0001, 16'd2, 8'd50, 1'b1);
        chk("R7 fault_unf", {28'd0, r_flags}, 32'h1);
        chk("R7 result kept", result, 32'h0002_0000);
        chk("R7 reads", rd_cnt - rd_base, 2);
        chk("R7 latency", n_edges, 5);
    endtask

    task automatic t_overflow();
        mem[60] = 32'h7FFF_0000; mem[61] = 32'h0; mem[62] = 32'h0;
        run(32'h7FFF_0000, 16'd2, 8'd60, 1'b0);
        chk("R6 prod ovf", {28'd0, r_flags}, 32'h2);
        chk("R6 result kept", result, 32'h0002_0000);
        chk("R6 reads", rd_cnt - rd_base, 2);
        chk("R6 latency", n_edges, 5);
        mem[70] = 32'h7FFF_0000; mem[71] = 32'h7FFF_0000;
        run(32'h0001_0000, 16'd1, 8'd70, 1'b0);
        chk("R6 sum ovf", {28'd0, r_flags}, 32'h2);
        chk("R6 sum result kept", result, 32'h0002_0000);
    endtask

    task automatic t_reserved();
        run(32'h0001_0000, 16'd32, 8'd4, 1'b0);
        chk("R4 fault_rsv", {31'd0, fault_rsv}, 1);
        chk("R4 no read", rd_cnt - rd_base, 0);
        chk("R4 latency", n_edges, 1);
        chk("R4 result kept", result, 32'h0002_0000);
        chk("R10 ovf cleared", {31'd0, fault_ovf}, 0);
        run(32'h0001_0000, 16'hFFFF, 8'd4, 1'b0);
        chk("R4 max deg fault", {31'd0, fault_rsv}, 1);
        run(32'h0002_0000, 16'd2, 8'd4, 1'b0);
        chk("R10 rsv cleared", {31'd0, fault_rsv}, 0);
        chk("R2 after fault", result, 32'h0003_0000);
    endtask

    task automatic t_deg31();
        for (int i = 0; i < 31; i++) mem[100 + i] = 32'h5;
        mem[131] = 32'h0000_0777;
        run(32'h0, 16'd31, 8'd100, 1'b1);
        chk("R2 deg31 result", result, 32'h0000_0777);
        chk_reads("R2 deg31 reads", 32, 8'd100);
        chk("R11 latency d31", n_edges, 65);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        arg_x = 32'h0002_0000; degree = 16'd2; base_addr = 8'd4; unf_trap = 1'b0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); @(negedge clk);
        arg_x = 32'h0000_0000; degree = 16'd40; base_addr = 8'd20; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk("R10 busy start ignored", result, 32'h0003_0000);
        chk("R10 no rsv while busy", {31'd0, fault_rsv}, 0);
        @(negedge clk); @(negedge clk);
        chk("R10 no second done", {31'd0, done}, 0);
        chk("R10 result hold", result, 32'h0003_0000);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_negative();
        t_zero_result();
        t_deg0();
        t_round();
        t_basic();
        t_underflow();
        t_overflow();
        t_reserved();
        t_deg31();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule